// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal request port and an external asynchronous static RAM that is 16 bits wide and has 19 address bits. Each accepted request moves one word. A write stores the bytes selected by a per-lane mask. A read fetches the selected byte lanes and returns them with a one-cycle valid strobe. The controller drives the address, two chip selects of opposite polarity, output enable, write enable and one active-low enable per byte lane. The data bus is split into drive, drive-enable and sample signals, so the pad ring can build the tri-state buffer.

Every analogue timing limit of the memory is given as a nanosecond parameter. The controller rounds each limit up to whole cycles of the configured clock period. Writes are timed by write enable and reads by output enable. After reset the controller waits a configurable settling time before it accepts the first request. It also inserts bus turnaround cycles when a write follows a read.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for exactly PWR = ceil(T_PWRUP_NS / CLK_NS) rising edges. During that time the memory stays deselected (`sram_sel_n` = 1, `sram_sel` = 0).
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the access completes. While `req_ready` is high, the device is deselected, `sram_we_n` = `sram_oe_n` = 1, all `sram_bsel_n` bits are 1, and `sram_dq_oe` = 0.
- R3: In a write, address, lane enables and data are driven for one cycle before `sram_we_n` falls. `sram_we_n` then stays low for WE = max(ceil(35/T), ceil(45/T)−2, ceil(25/T)−1, 1) cycles. Address, data and drive stay unchanged for one cycle after `sram_we_n` rises. Here T is CLK_NS.
- R4: `req_be` bit 0 selects bits 7:0 and drives `sram_bsel_n[0]` low. Bit 1 selects bits 15:8 via `sram_bsel_n[1]`. A lane with its bit at 0 keeps its enable high, so its memory byte is left unchanged. A write with mask 00 changes nothing.
- R5: In a read, `sram_dq_oe` goes low one cycle before `sram_oe_n` falls and stays low while `sram_oe_n` is low. `sram_we_n` stays high throughout the read.
- R6: `sram_oe_n` stays low for RD = max(ceil(45/T)−1, ceil(22/T), 1) cycles. The bus is sampled on the edge that ends this window. In the following cycle, `rd_valid` is high for exactly one cycle and `req_ready` is high again.
- R7: In `rd_data`, every lane whose `req_be` bit was 0 reads as zero, whatever the bus carried.
- R8: When a write is accepted and the previous access was a read, TA = ceil(18/T) deselected cycles come before the write's setup cycle. No other pair of accesses gets extra cycles. The data drivers are never on while output enable is low or within 18 ns after it rises.
- R9: `sram_we_n` and `sram_oe_n` are never low together. `sram_we_n` is low only while the device is selected and the data drivers are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane select, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DATA_W | Read data, unselected lanes zero |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_sel | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_bsel_n | output | DATA_W/8 | Byte-lane enables, active low |
| sram_dq_o | output | DATA_W | Data to drive onto the bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | DATA_W | Data sampled from the bus |

## Verification
The bench builds the controller with a 20 ns clock and a settling time shortened to 2 µs, which gives 100 cycles. With these values WE = 2, RD = 2 and TA = 1, so each rounding formula has its limit within one cycle of the real nanosecond bound. A shortened write pulse or read window therefore shows up as a timing violation in the behavioural memory. That memory returns inverted data when it is sampled before the access time and puts filler on lanes that are not enabled. This exposes early sampling and masking errors. Read-then-write pairs, masks 00 to 11, and the highest address are all driven, together with random traffic.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and cycle-rounding helpers for the static RAM controller.
// Assumes all timing inputs are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RSETUP,
        ST_RWAIT
    } ctl_state_t;

    // Round a nanosecond bound up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
// Down-counter for the phases that last several cycles.
// Loading N-1 gives a phase of N cycles; expired marks the last one.
module sram_ctrl_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_pwrup.sv
`timescale 1ns/1ps
// Settling-time counter after reset. done rises after CYC rising edges
// and stays high until the next reset.
module sram_ctrl_pwrup #(
    parameter int CYC = 15000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = (CYC > 1) ? $clog2(CYC + 1) : 1;
    localparam logic [W-1:0] LIMIT = W'(CYC);

    logic [W-1:0] cnt;

    // Count edges since reset and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/sram_ctrl_rdlane.sv
`timescale 1ns/1ps
// Read-data capture, one 8-bit register per byte lane. Lanes not selected
// for the read are cleared, so floating bus bits never reach rd_data.
module sram_ctrl_rdlane #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [8*LANES-1:0] dq_i,
    output logic [8*LANES-1:0] rd_data,
    output logic               rd_valid
);
    // One-cycle strobe in the cycle after capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= capture;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Take the lane from the bus when selected, zero otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_data[8*l +: 8] <= '0;
            else if (capture)
                rd_data[8*l +: 8] <= lane_en[l] ? dq_i[8*l +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
// Controller for an asynchronous static RAM, one word per request.
// Writes are timed by write enable and reads by output enable. Phase
// lengths are nanosecond limits rounded up to clock cycles. Assumes the
// pad ring builds the tri-state buffer from dq_o / dq_oe / dq_i, and that
// the pins settle within one clock period of the edge that sets them.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 20,
    parameter int T_WC_NS    = 45,
    parameter int T_RC_NS    = 45,
    parameter int T_PWE_NS   = 35,
    parameter int T_SD_NS    = 25,
    parameter int T_AA_NS    = 45,
    parameter int T_DOE_NS   = 22,
    parameter int T_HZ_NS    = 18,
    parameter int T_PWRUP_NS = 300000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic                sram_sel_n,
    output logic                sram_sel,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic [DATA_W/8-1:0] sram_bsel_n,
    output logic [DATA_W-1:0]   sram_dq_o,
    output logic                sram_dq_oe,
    input  logic [DATA_W-1:0]   sram_dq_i
);
    localparam int LANES   = DATA_W / 8;
    localparam int N_WE    = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS) - 2),
                                  imax(ns_to_cyc(T_SD_NS, CLK_NS) - 1, 1));
    localparam int N_RD    = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS) - 1, ns_to_cyc(T_RC_NS, CLK_NS) - 1),
                                  imax(ns_to_cyc(T_DOE_NS, CLK_NS), 1));
    localparam int N_TA    = imax(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
    localparam int PWR_CYC = ns_to_cyc(T_PWRUP_NS, CLK_NS);
    localparam int CNT_W   = $clog2(imax(imax(N_WE, N_RD), N_TA) + 1);

    ctl_state_t          state;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    be_q;
    logic                last_rd;
    logic                pwr_done;
    logic                accept;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_exp;
    logic                capture;
    logic                sel_act;

    sram_ctrl_pwrup #(.CYC(PWR_CYC)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sram_ctrl_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sram_ctrl_rdlane #(.LANES(LANES)) u_rdlane (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .lane_en  (be_q),
        .dq_i     (sram_dq_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign req_ready = pwr_done && (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == ST_RWAIT) && tmr_exp;

    // Load the timer on entry to each multi-cycle phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: if (accept && req_write && last_rd) begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_TA - 1);
            end
            ST_WSETUP: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_WE - 1);
            end
            ST_RSETUP: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_RD - 1);
            end
            default: ;
        endcase
    end

    // Sequence one access and hold its request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            last_rd <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    be_q    <= req_be;
                    last_rd <= !req_write;
                    if (!req_write)
                        state <= ST_RSETUP;
                    else if (last_rd)
                        state <= ST_TURN;
                    else
                        state <= ST_WSETUP;
                end
                ST_TURN:   if (tmr_exp) state <= ST_WSETUP;
                ST_WSETUP: state <= ST_WPULSE;
                ST_WPULSE: if (tmr_exp) state <= ST_WHOLD;
                ST_WHOLD:  state <= ST_IDLE;
                ST_RSETUP: state <= ST_RWAIT;
                ST_RWAIT:  if (tmr_exp) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Decode the memory pins from the phase and the held fields.
    always_comb begin
        sel_act     = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD)
                   || (state == ST_RSETUP) || (state == ST_RWAIT);
        sram_sel_n  = !sel_act;
        sram_sel    = sel_act;
        sram_bsel_n = sel_act ? ~be_q : '1;
        sram_we_n   = (state != ST_WPULSE);
        sram_oe_n   = (state != ST_RWAIT);
        sram_dq_oe  = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
        sram_dq_o   = wdata_q;
        sram_addr   = addr_q;
    end
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for sram_ctrl, attached by bind. Watches the pins only.
module sram_ctrl_chk #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 20,
    parameter int T_PWRUP_NS = 300000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                rd_valid,
    input logic [ADDR_W-1:0]   sram_addr,
    input logic                sram_sel_n,
    input logic                sram_sel,
    input logic                sram_we_n,
    input logic                sram_oe_n,
    input logic [DATA_W/8-1:0] sram_bsel_n,
    input logic [DATA_W-1:0]   sram_dq_o,
    input logic                sram_dq_oe
);
    localparam int PWR = (T_PWRUP_NS + CLK_NS - 1) / CLK_NS;
    localparam int W   = $clog2(PWR + 2);

    logic [W-1:0] since_rst;

    // Count edges since reset, saturating, for the settling-time check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != W'(PWR))
            since_rst <= since_rst + 1'b1;
    end

    a_r1_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (since_rst == W'(PWR)));

    a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_sel_n && !sram_sel && sram_we_n && sram_oe_n
                       && !sram_dq_oe && (&sram_bsel_n)));

    a_r3_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($past(sram_dq_oe) && $stable(sram_addr) && $stable(sram_dq_o)));

    a_r3_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_o)
                              && $stable(sram_bsel_n)));

    a_r5_released_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> (!$past(sram_dq_oe) && !sram_dq_oe && sram_we_n));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r6_strobe_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!sram_oe_n) && sram_oe_n && req_ready));

    a_r9_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    a_r9_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_sel_n && sram_sel && sram_dq_oe));
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CLK_NS     (CLK_NS),
    .T_PWRUP_NS (T_PWRUP_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .sram_addr   (sram_addr),
    .sram_sel_n  (sram_sel_n),
    .sram_sel    (sram_sel),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_bsel_n (sram_bsel_n),
    .sram_dq_o   (sram_dq_o),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural memory with timing checks, plus a cycle model of
// ready / read strobe / read data compared every clock.
module sram_ctrl_bench;
    localparam int CLK_NS   = 20;
    localparam int ADDR_W   = 19;
    localparam int DATA_W   = 16;
    localparam int LANES    = 2;
    localparam int PWRUP_NS = 2000;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int PWR  = cdiv(PWRUP_NS, CLK_NS);
    localparam int E_WE = mx(mx(cdiv(35, CLK_NS), cdiv(45, CLK_NS) - 2), mx(cdiv(25, CLK_NS) - 1, 1));
    localparam int E_RD = mx(cdiv(45, CLK_NS) - 1, mx(cdiv(22, CLK_NS), 1));
    localparam int E_TA = mx(cdiv(18, CLK_NS), 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic [DATA_W-1:0]   req_wdata = '0;
    logic [LANES-1:0]    req_be = '0;
    logic                rd_valid;
    logic [DATA_W-1:0]   rd_data;
    logic [ADDR_W-1:0]   sram_addr;
    logic                sram_sel_n, sram_sel, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [LANES-1:0]    sram_bsel_n;
    logic [DATA_W-1:0]   sram_dq_o;
    logic [DATA_W-1:0]   sram_dq_i = '0;

    sram_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS), .T_PWRUP_NS(PWRUP_NS)
    ) u_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
        .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_bsel_n(sram_bsel_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    always #(CLK_NS/2) clk = ~clk;

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] init_val(input int a);
        return 16'(a) ^ 16'h3C96;
    endfunction

    // ---------------- behavioural memory ----------------
    logic [15:0] ram_mem [int];
    real t_edge = 0.0, t_addr = 0.0, t_data = 0.0;
    real t_we_fall = 0.0, t_oe_fall = 0.0, t_oe_rise = -1000.0;
    logic [ADDR_W-1:0] p_addr = '0;
    logic [DATA_W-1:0] p_dq = '0;
    logic [LANES-1:0]  p_bsel = '1;
    logic p_we = 1'b1, p_oe = 1'b1, p_drv = 1'b0;

    function automatic logic [15:0] ram_rd(input int a);
        return ram_mem.exists(a) ? ram_mem[a] : init_val(a);
    endfunction

    always @(posedge clk) t_edge = $realtime;

    // Pin monitor: timing checks at each edge, writes committed on we_n rising.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] w;
            chk(!(!sram_we_n && !sram_oe_n), "R9", "we/oe both low", 0, 0);
            if (p_we && !sram_we_n) begin
                chk(sram_addr == p_addr && p_drv && sram_dq_o == p_dq, "R3", "setup before we fall", 32'(sram_addr), 32'(p_addr));
                chk(!sram_sel_n && sram_sel && sram_dq_oe, "R9", "we low without select/drive", 0, 1);
                t_we_fall = t_edge;
            end
            if (!p_we && sram_we_n) begin
                chk(t_edge - t_we_fall >= 35.0, "R3", "we pulse ns", 32'($rtoi(t_edge - t_we_fall)), 35);
                chk(t_edge - t_data >= 25.0, "R3", "data setup ns", 32'($rtoi(t_edge - t_data)), 25);
                chk(sram_addr == p_addr && sram_dq_o == p_dq && sram_dq_oe && sram_bsel_n == p_bsel,
                    "R3", "hold after we rise", 32'(sram_dq_o), 32'(p_dq));
                w = ram_rd(int'(p_addr));
                for (int l = 0; l < LANES; l++)
                    if (!p_bsel[l]) w[8*l +: 8] = p_dq[8*l +: 8];
                ram_mem[int'(p_addr)] = w;
            end
            if (p_oe && !sram_oe_n) begin
                chk(!p_drv && !sram_dq_oe && sram_we_n, "R5", "drivers off before oe", 32'(p_drv), 0);
                t_oe_fall = t_edge;
            end
            if (!p_oe && sram_oe_n) t_oe_rise = t_edge;
            if (sram_dq_oe)
                chk(sram_oe_n && (t_edge - t_oe_rise) >= 18.0, "R8", "bus contention", 32'(sram_oe_n), 1);
            if (sram_addr != p_addr) t_addr = t_edge;
            if (sram_dq_o != p_dq || sram_dq_oe != p_drv) t_data = t_edge;
        end
        p_addr = sram_addr; p_dq = sram_dq_o; p_bsel = sram_bsel_n;
        p_we = sram_we_n; p_oe = sram_oe_n; p_drv = sram_dq_oe;
    end

    // Memory output 1 ns before each edge: valid only after access times.
    initial forever begin
        @(posedge clk);
        #(CLK_NS - 1);
        begin
            real te;
            logic [15:0] m, d;
            te = $realtime + 1.0;
            m = ram_rd(int'(sram_addr));
            for (int l = 0; l < LANES; l++) begin
                if (!sram_sel_n && sram_sel && sram_we_n && !sram_oe_n && !sram_bsel_n[l])
                    d[8*l +: 8] = (te - t_addr >= 45.0 && te - t_oe_fall >= 22.0)
                                  ? m[8*l +: 8] : ~m[8*l +: 8];
                else
                    d[8*l +: 8] = 8'hA5;
            end
            sram_dq_i = d;
        end
    end

    // ---------------- cycle reference model ----------------
    logic [15:0] ref_mem [int];
    int pwr_cnt = 0;
    int busy = 0;
    bit rd_flag = 0;
    bit last_rd = 0;
    bit exp_ready = 0;
    logic [15:0] rd_exp = '0;

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    task automatic tick();
        @(negedge clk);
        exp_ready = (pwr_cnt >= PWR) && (busy == 0);
        chk(req_ready == exp_ready, (pwr_cnt < PWR) ? "R1" : "R2", "ready", 32'(req_ready), 32'(exp_ready));
        if (pwr_cnt < PWR)
            chk(sram_sel_n && !sram_sel, "R1", "selected during settling", 32'(sram_sel), 0);
        if (exp_ready)
            chk(sram_sel_n && !sram_sel && sram_we_n && sram_oe_n && !sram_dq_oe && (&sram_bsel_n),
                "R2", "idle pins", {sram_we_n, sram_oe_n, sram_dq_oe, sram_bsel_n}, 32'h1B);
        if (rd_flag && busy == 0) begin
            chk(rd_valid == 1'b1, "R6", "rd_valid", 32'(rd_valid), 1);
            chk(rd_data == rd_exp, "R6/R7", "rd_data", 32'(rd_data), 32'(rd_exp));
            rd_flag = 0;
        end else begin
            chk(rd_valid == 1'b0, "R6", "stray rd_valid", 32'(rd_valid), 0);
        end
    endtask

    task automatic advance();
        bit acc;
        logic [15:0] w;
        acc = req_valid && exp_ready;
        pwr_cnt++;
        if (busy > 0) busy--;
        if (acc) begin
            if (req_write) begin
                busy = (last_rd ? E_TA : 0) + E_WE + 2;   // R8 turnaround, R3 phases
                w = ref_rd(int'(req_addr));
                for (int l = 0; l < LANES; l++)
                    if (req_be[l]) w[8*l +: 8] = req_wdata[8*l +: 8];   // R4 masking
                ref_mem[int'(req_addr)] = w;
                last_rd = 0;
            end else begin
                busy = E_RD + 1;
                w = ref_rd(int'(req_addr));
                for (int l = 0; l < LANES; l++)
                    if (!req_be[l]) w[8*l +: 8] = 8'h00;             // R7 zero lanes
                rd_exp = w;
                rd_flag = 1;
                last_rd = 1;
            end
        end
    endtask

    task automatic issue(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        bit acc = 0;
        while (!acc) begin
            tick();
            req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
            acc = exp_ready;
            advance();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            req_valid = 1'b0;
            req_wdata = 16'($urandom);
            advance();
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [ADDR_W-1:0] pool [8];
        pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00010; pool[3] = 19'h2AAAA;
        pool[4] = 19'h55555; pool[5] = 19'h00001; pool[6] = 19'h40000; pool[7] = 19'h12345;
        repeat (3) @(negedge clk);
        chk(!req_ready && !rd_valid && sram_sel_n && !sram_sel && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R2", "reset state", 32'(req_ready), 0);
        rst_n = 1'b1;
        advance();
        // R1: request held during settling, taken only after PWR edges
        issue(1, 19'h00010, 16'hBEEF, 2'b11);
        issue(0, 19'h00010, 16'h0000, 2'b11);          // R6 full read
        issue(1, 19'h00010, 16'h1234, 2'b01);          // R8 read then write, R4 low lane
        issue(0, 19'h00010, 16'h0000, 2'b11);          // expect BE34
        issue(1, 19'h00010, 16'hAB00, 2'b10);          // R4 high lane
        issue(1, 19'h00010, 16'hFFFF, 2'b00);          // R4 empty mask
        issue(0, 19'h00010, 16'h0000, 2'b11);          // expect AB34
        issue(0, 19'h00010, 16'h0000, 2'b01);          // R7 upper lane zero
        issue(0, 19'h00010, 16'h0000, 2'b10);          // R7 lower lane zero
        issue(0, 19'h7FFFF, 16'h0000, 2'b11);          // top address, initial content
        issue(1, 19'h7FFFF, 16'h5AA5, 2'b11);
        idle(3);
        issue(0, 19'h7FFFF, 16'h0000, 2'b11);
        issue(0, 19'h00000, 16'h0000, 2'b00);          // R7 empty read mask
        for (int i = 0; i < 300; i++) begin
            issue(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom));
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        for (int i = 0; i < 8; i++) issue(0, pool[i], 16'h0000, 2'b11);
        idle(E_RD + 4);
        finish_run();
    end
endmodule